// File: doc/BRIEF.md
# Resettable Synchronization Clock Divider

This block derives a slow synchronization clock from a fast system clock by dividing it by 16. After power-up the divider can sit in any of its 16 phase states, so two copies of the block fed by the same system clock can disagree on where their sync clock edges fall. The block therefore accepts an external sync input. It passes that input through a two-flop synchronizer and a rising-edge detector, then through a programmable delay of whole system-clock cycles. The resulting event forces the divider back to phase zero, but only while a realignment has been armed by a calibration strobe issued with the cal-with-sync control high.

A second, much slower square wave, the master sync output, runs at 1/384 of the system clock while its enable is high. It is meant to be fanned out to the sync inputs of every block in a group, including the one that produced it. The sync input source must run at an integer submultiple of the system clock. A one-sync-period flag reports that a realignment has just taken place. Because the delay is counted in whole system-clock cycles, a larger delay code moves the realigned sync clock edge later by exactly that many system-clock periods.

Top module: `syncdiv_top`

## Requirements
- R1: While no realignment occurs, the internal divider phase advances by one every system clock and wraps from 15 to 0; `sync_clk` is low for phases 0 to 7 and high for phases 8 to 15, giving a period of 16 cycles with a 50 % duty cycle.
- R2: While `rst_n` is low at a clock edge, the divider phase is loaded from `boot_phase`, and `aligned` and `sync_out` are 0, so any of the 16 starting phases can be seeded.
- R3: `sync_in` passes through two flip-flops and then a rising-edge detector, so a level held high for many cycles produces exactly one realignment event.
- R4: With delay code d (0 to 7), if `sync_in` is first seen high at clock edge E, an armed realignment sets the divider phase to 0 after edge E+2+d. The `sync_clk` rising edge therefore moves by exactly d system-clock periods.
- R5: A sync event that arrives while no realignment is armed leaves the divider phase and `aligned` unchanged.
- R6: An armed realignment is used up by the first sync event. Later sync events are ignored until a new calibration strobe arrives.
- R7: While `sync_out_en` is high, `sync_out` is a square wave with a period of 384 cycles. It starts high for 192 cycles from the edge after the enable is first seen, then is low for 192 cycles. One edge after the enable is seen low, `sync_out` is 0.
- R8: `aligned` goes high on the same edge that sets the divider phase to 0 and stays high for exactly 16 cycles, one full sync clock period. It is then 0 until the next realignment.
- R9: A realignment is armed only by a `cal_strobe` sampled while `cal_sync_en` is 1. A strobe with `cal_sync_en` at 0 arms nothing, and driving `cal_sync_en` to 0 cancels a pending arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_phase | input | 4 | Divider phase loaded while in reset |
| sync_in | input | 1 | External sync input, asynchronous |
| sync_out_en | input | 1 | Enables the master sync output |
| cal_sync_en | input | 1 | Cal-with-sync control; must be 1 to arm a realignment |
| cal_strobe | input | 1 | One-cycle calibration strobe |
| dly_code | input | 3 | Sync input delay in system-clock cycles, 0 to 7 |
| sync_clk | output | 1 | Divided-by-16 sync clock |
| sync_out | output | 1 | Master sync output at 1/384 of the system clock |
| aligned | output | 1 | High for one sync clock period after a realignment |

## Verification
The embedded assertions check the following on every cycle:
- the divider wrap, and the return of the phase to zero on a realignment;
- that a realignment happens only while armed;
- that an arm is used up by a realignment and created only by a qualified strobe;
- that the edge detector yields single-cycle events;
- that `sync_out` is silent when disabled.

The bench's scenarios are needed for the rest. These are the exact edge at which realignment lands for several delay codes, the one-event-per-level behaviour of a long `sync_in` pulse, and the ignored pulses with no arm, with a strobe while disabled and with a cancelled arm. The full 384-cycle shape of `sync_out` and the seeding of different boot phases are also shown only by the scenarios.

// File: rtl/syncdiv_pkg.sv
package syncdiv_pkg;

   // Default geometry of the divider family
   localparam int unsigned DEF_DIV_RATIO   = 16;
   localparam int unsigned DEF_OUT_RATIO   = 384;
   localparam int unsigned DEF_DLY_W       = 3;
   localparam int unsigned DEF_SYNC_STAGES = 2;

   // Realignment arming state
   typedef enum logic {
      ARM_IDLE = 1'b0,
      ARM_WAIT = 1'b1
   } arm_e;

endpackage

// File: rtl/syncdiv_phase_ctr.sv
module syncdiv_phase_ctr #(
   parameter int unsigned DIV_RATIO = 16,
   localparam int unsigned PH_W     = $clog2(DIV_RATIO),
   localparam int unsigned HALF     = DIV_RATIO / 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PH_W-1:0] boot_phase,
   input  logic            clr,
   output logic [PH_W-1:0] phase,
   output logic            sync_clk
);

   localparam logic [PH_W-1:0] LAST = PH_W'(DIV_RATIO - 1);
   localparam logic [PH_W-1:0] MID  = PH_W'(HALF);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= boot_phase;
      end else if (clr) begin
         phase <= '0;
      end else if (phase == LAST) begin
         phase <= '0;
      end else begin
         phase <= phase + 1'b1;
      end
   end

   assign sync_clk = (phase >= MID);

   // R1: free-running divider wraps to zero after its last phase
   a_r1_wrap : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && phase == LAST) |=> phase == '0);

   // R1: outside realignment the phase never stands still
   a_r1_moves : assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> !$stable(phase));

   // R4: a realignment lands on phase zero
   a_r4_clear : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> phase == '0);

endmodule

// File: rtl/syncdiv_in_path.sv
module syncdiv_in_path #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DLY_W       = 3,
   localparam int unsigned MAX_DLY    = (1 << DLY_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_in,
   input  logic [DLY_W-1:0] dly_code,
   output logic             event_o
);

   // synchronizer chain plus one extra flop for edge detection
   logic [SYNC_STAGES:0] chain;
   logic                 rise;
   logic [MAX_DLY:1]     hist;
   logic [MAX_DLY:0]     taps;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[SYNC_STAGES-1:0], sync_in};
      end
   end

   assign rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

   // delay line, one register per system-clock cycle of delay
   for (genvar k = 1; k <= MAX_DLY; k++) begin : g_dly
      if (k == 1) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) hist[k] <= 1'b0;
            else        hist[k] <= rise;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) hist[k] <= 1'b0;
            else        hist[k] <= hist[k-1];
         end
      end
   end

   assign taps    = {hist, rise};
   assign event_o = taps[dly_code];

   // R3: the edge detector produces single-cycle events
   a_r3_single : assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

   // R3: an event needs a low sample behind a high one in the chain
   a_r3_edge : assert property (@(posedge clk) disable iff (!rst_n)
      rise |-> $past(chain[SYNC_STAGES-2]) && !chain[SYNC_STAGES]);

endmodule

// File: rtl/syncdiv_out_gen.sv
module syncdiv_out_gen #(
   parameter int unsigned OUT_RATIO = 384,
   localparam int unsigned CNT_W    = $clog2(OUT_RATIO),
   localparam int unsigned HALF     = OUT_RATIO / 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic sync_out
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(OUT_RATIO - 1);
   localparam logic [CNT_W-1:0] MID  = CNT_W'(HALF);

   logic             run;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run <= 1'b0;
         cnt <= '0;
      end else begin
         run <= en;
         if (!run || cnt == LAST) cnt <= '0;
         else                     cnt <= cnt + 1'b1;
      end
   end

   assign sync_out = run && (cnt < MID);

   // R7: the output is quiet one edge after the enable drops
   a_r7_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !sync_out);

   // R7: a fresh enable starts with the high half
   a_r7_start : assert property (@(posedge clk) disable iff (!rst_n)
      (en && !run) |=> sync_out);

endmodule

// File: rtl/syncdiv_top.sv
module syncdiv_top
   import syncdiv_pkg::*;
#(
   parameter int unsigned DIV_RATIO   = DEF_DIV_RATIO,
   parameter int unsigned OUT_RATIO   = DEF_OUT_RATIO,
   parameter int unsigned DLY_W       = DEF_DLY_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
   localparam int unsigned PH_W       = $clog2(DIV_RATIO),
   localparam int unsigned FLAG_W     = $clog2(DIV_RATIO + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PH_W-1:0]  boot_phase,
   input  logic             sync_in,
   input  logic             sync_out_en,
   input  logic             cal_sync_en,
   input  logic             cal_strobe,
   input  logic [DLY_W-1:0] dly_code,
   output logic             sync_clk,
   output logic             sync_out,
   output logic             aligned
);

   // elaboration-time parameter checks
   if (DIV_RATIO < 2 || (DIV_RATIO % 2) != 0 || (1 << PH_W) != DIV_RATIO) begin : g_bad_div
      $error("DIV_RATIO must be an even power of two");
   end
   if (OUT_RATIO < 2 || (OUT_RATIO % 2) != 0) begin : g_bad_out
      $error("OUT_RATIO must be even and at least 2");
   end
   if (DLY_W < 1 || DLY_W > 6) begin : g_bad_dly
      $error("DLY_W must lie in 1..6");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   localparam logic [FLAG_W-1:0] FLAG_LEN = FLAG_W'(DIV_RATIO);

   logic              sync_evt;
   logic              realign;
   logic [PH_W-1:0]   div_phase;
   logic [FLAG_W-1:0] flag_cnt;
   arm_e              arm_q;
   arm_e              arm_d;

   syncdiv_in_path #(
      .SYNC_STAGES (SYNC_STAGES),
      .DLY_W       (DLY_W)
   ) u_in (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_in  (sync_in),
      .dly_code (dly_code),
      .event_o  (sync_evt)
   );

   // arming: a qualified strobe arms, the first sync event consumes it
   assign realign = (arm_q == ARM_WAIT) && sync_evt;

   always_comb begin
      arm_d = arm_q;
      if (!cal_sync_en)                    arm_d = ARM_IDLE;
      else if (cal_strobe)                 arm_d = ARM_WAIT;
      else if (realign)                    arm_d = ARM_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) arm_q <= ARM_IDLE;
      else        arm_q <= arm_d;
   end

   syncdiv_phase_ctr #(
      .DIV_RATIO (DIV_RATIO)
   ) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .boot_phase (boot_phase),
      .clr        (realign),
      .phase      (div_phase),
      .sync_clk   (sync_clk)
   );

   syncdiv_out_gen #(
      .OUT_RATIO (OUT_RATIO)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (sync_out_en),
      .sync_out (sync_out)
   );

   // aligned flag: one full sync clock period after realignment
   always_ff @(posedge clk) begin
      if (!rst_n)              flag_cnt <= '0;
      else if (realign)        flag_cnt <= FLAG_LEN;
      else if (flag_cnt != '0) flag_cnt <= flag_cnt - 1'b1;
   end

   assign aligned = (flag_cnt != '0);

   // R5: a sync event without an arm leaves the divider free-running
   a_r5_need_arm : assert property (@(posedge clk) disable iff (!rst_n)
      (sync_evt && arm_q == ARM_IDLE) |-> !realign);

   // R6: a realignment consumes the arm unless a new strobe arrives
   a_r6_consume : assert property (@(posedge clk) disable iff (!rst_n)
      (realign && !cal_strobe) |=> arm_q == ARM_IDLE);

   // R9: the arm appears only from a strobe with cal-with-sync set
   a_r9_arm_src : assert property (@(posedge clk) disable iff (!rst_n)
      (arm_q == ARM_IDLE && !(cal_strobe && cal_sync_en)) |=> arm_q == ARM_IDLE);

   // R9: clearing cal-with-sync cancels any pending arm
   a_r9_cancel : assert property (@(posedge clk) disable iff (!rst_n)
      !cal_sync_en |=> arm_q == ARM_IDLE);

   // R8: flag rises together with phase zero
   a_r8_flag : assert property (@(posedge clk) disable iff (!rst_n)
      realign |=> aligned && div_phase == '0);

   // R8: flag only rises on a realignment
   a_r8_source : assert property (@(posedge clk) disable iff (!rst_n)
      (!aligned && !realign) |=> !aligned);

endmodule

// File: tb/syncdiv_top_tb_top.sv
module syncdiv_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] boot_phase = 4'd5;
   logic       sync_in = 1'b0;
   logic       sync_out_en = 1'b0;
   logic       cal_sync_en = 1'b0;
   logic       cal_strobe = 1'b0;
   logic [2:0] dly_code = 3'd0;
   logic       sync_clk;
   logic       sync_out;
   logic       aligned;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   string cur_tag = "R2";

   always #10 clk = ~clk;   // 50 MHz

   syncdiv_top dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .boot_phase  (boot_phase),
      .sync_in     (sync_in),
      .sync_out_en (sync_out_en),
      .cal_sync_en (cal_sync_en),
      .cal_strobe  (cal_strobe),
      .dly_code    (dly_code),
      .sync_clk    (sync_clk),
      .sync_out    (sync_out),
      .aligned     (aligned)
   );

   // ---------------- reference model from the requirements ----------------
   typedef struct {
      bit sclk;
      bit aln;
      bit sout;
   } exp_t;

   exp_t exp_q[$];

   int m_phase, m_flag, m_so_cnt;
   bit m_run, m_armed, m_s1, m_s2, m_s3;
   bit m_hist[1:7];

   always @(posedge clk) begin
      bit rise, tap, realign;
      exp_t e;
      if (!rst_n) begin
         m_phase = boot_phase; m_flag = 0; m_so_cnt = 0;
         m_run = 0; m_armed = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
         for (int k = 1; k <= 7; k++) m_hist[k] = 0;
      end else begin
         rise    = m_s2 && !m_s3;                          // R3
         tap     = (dly_code == 0) ? rise : m_hist[dly_code]; // R4
         realign = m_armed && tap;                         // R5
         m_phase = realign ? 0 : (m_phase + 1) % 16;       // R1
         m_flag  = realign ? 16 : (m_flag > 0 ? m_flag - 1 : 0); // R8
         m_armed = cal_sync_en && (cal_strobe || (m_armed && !realign)); // R6 R9
         m_so_cnt = (!m_run || m_so_cnt == 383) ? 0 : m_so_cnt + 1; // R7
         m_run   = sync_out_en;
         for (int k = 7; k >= 2; k--) m_hist[k] = m_hist[k-1];
         m_hist[1] = rise;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = sync_in;
      end
      e.sclk = (m_phase >= 8);
      e.aln  = (m_flag != 0);
      e.sout = m_run && (m_so_cnt < 192);
      exp_q.push_back(e);
   end

   // ---------------- monitor / scoreboard ----------------
   int aln_rises = 0;
   bit aln_prev  = 1'b0;

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      exp_t e;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         check(cur_tag, "sync_clk", sync_clk, e.sclk);
         check("R8", "aligned", aligned, e.aln);
         check("R7", "sync_out", sync_out, e.sout);
      end
      if (aligned && !aln_prev) aln_rises++;
      aln_prev = aligned;
   end

   // ---------------- driver ----------------
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic arm_cal(input bit en);
      @(negedge clk);
      cal_sync_en = en;
      cal_strobe  = 1'b1;
      @(negedge clk);
      cal_strobe  = 1'b0;
   endtask

   task automatic pulse(input int len);
      @(negedge clk);
      sync_in = 1'b1;
      idle(len);
      sync_in = 1'b0;
   endtask

   task automatic do_reset(input logic [3:0] ph);
      @(negedge clk);
      rst_n = 1'b0;
      boot_phase = ph;
      idle(3);
      // R2: reset state at the ports
      check("R2", "aligned in reset", aligned, 0);
      check("R2", "sync_out in reset", sync_out, 0);
      check("R2", "sync_clk in reset", sync_clk, (ph >= 8) ? 1 : 0);
      rst_n = 1'b1;
   endtask

   initial begin
      int base;
      do_reset(4'd5);
      cur_tag = "R1";
      idle(40);

      // R5: sync pulse without any arm
      cur_tag = "R5";
      base = aln_rises;
      pulse(4);
      idle(30);
      check("R5", "aligned rises without arm", aln_rises - base, 0);

      // R9: strobe with cal-with-sync low arms nothing
      cur_tag = "R9";
      base = aln_rises;
      arm_cal(1'b0);
      pulse(3);
      idle(30);
      check("R9", "aligned rises after unqualified strobe", aln_rises - base, 0);

      // R3 / R4: delay 0, long level gives exactly one event
      cur_tag = "R3";
      dly_code = 3'd0;
      base = aln_rises;
      arm_cal(1'b1);
      pulse(60);
      idle(30);
      check("R3", "aligned rises for one long level", aln_rises - base, 1);

      // R4: delay 5
      cur_tag = "R4";
      dly_code = 3'd5;
      base = aln_rises;
      arm_cal(1'b1);
      idle(7);
      pulse(3);
      idle(40);
      check("R4", "aligned rises with delay 5", aln_rises - base, 1);

      // R6: second pulse without a new strobe is ignored
      cur_tag = "R6";
      base = aln_rises;
      pulse(3);
      idle(40);
      check("R6", "aligned rises on unarmed second pulse", aln_rises - base, 0);

      // R9: arm then cancel by clearing cal-with-sync
      cur_tag = "R9";
      dly_code = 3'd7;
      base = aln_rises;
      arm_cal(1'b1);
      idle(2);
      cal_sync_en = 1'b0;
      pulse(3);
      idle(30);
      check("R9", "aligned rises after cancelled arm", aln_rises - base, 0);

      // R4: delay 7 with the arm kept
      cur_tag = "R4";
      base = aln_rises;
      arm_cal(1'b1);
      idle(5);
      pulse(2);
      idle(40);
      check("R4", "aligned rises with delay 7", aln_rises - base, 1);

      // R7: master sync output over more than two periods
      cur_tag = "R7";
      sync_out_en = 1'b1;
      idle(900);
      sync_out_en = 1'b0;
      idle(20);

      // R2: reseed to another phase
      cur_tag = "R2";
      do_reset(4'd11);
      idle(40);

      done = 1'b1;
      idle(2);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule